// File: doc/BRIEF.md
# Edge-Triggered Counter Capture Unit

This block timestamps events. It watches one trigger line, which is either an external capture input or the output of an analog comparator. When it sees an edge of the chosen polarity, it copies the value of a free-running counter into a capture register and sets a capture flag. The interrupt request follows the flag when interrupts are enabled.

The trigger passes through a synchronizer. An optional filter can follow, and it demands a run of identical samples before it accepts a new level. The capture register is wider than the bus, so software reaches it one byte at a time through a shared temporary byte.

Reading the low byte takes a copy of the high byte into the temporary byte, so the two halves always belong together. For writes the order is reversed: the high byte goes to the temporary byte first, and the low-byte write then commits the whole word. That commit only happens when the counter's waveform mode uses the capture register as its TOP value.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset the following are all 0: the capture flag, the interrupt request, the capture register and the temporary byte.
- R2: With `edgeRise`=1, a 0-to-1 change of the selected trigger causes a capture. With `edgeRise`=0, a 1-to-0 change causes one. A change in the other direction captures nothing.
- R3: With `srcSel`=0 the trigger is `pinIn`, and with `srcSel`=1 it is `cmpIn`. Activity on the unselected input has no effect.
- R4: With the filter off, a trigger change that is present at clock edge k is captured at edge k+2. The capture register takes `cntVal` as sampled at that edge, and the flag is set on the same edge.
- R5: With `filtEn`=1, a new trigger level is accepted only after four equal consecutive samples. This adds four clock cycles to the capture latency of R4, and a pulse shorter than four cycles produces no capture.
- R6: `irq` is 1 exactly when the flag is set and `irqEn`=1.
- R7: The flag is cleared by `intAck`, or by a bus write to address 2 with data bit 0 set. A write with bit 0 clear leaves the flag alone.
- R8: If a capture and a flag clear happen in the same cycle, the capture wins and the flag stays set.
- R9: A read of address 0 returns the low byte of the capture register and copies its high byte into the temporary byte. A read of address 1 returns the temporary byte, and address 2 returns the flag in bit 0.
- R10: A write to address 1 loads the temporary byte. A write to address 0 with `topMode`=1 loads the capture register with {temporary byte, data}. With `topMode`=0 that write is ignored.
- R11: Switching `srcSel` while the two synchronized inputs differ is treated as a trigger change, and it captures if the change matches the chosen polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | 1 | External capture input (asynchronous) |
| cmpIn | input | 1 | Comparator output (asynchronous) |
| srcSel | input | 1 | Trigger source: 0 selects pin, 1 selects comparator |
| edgeRise | input | 1 | Edge polarity: 1 selects rising, 0 selects falling |
| filtEn | input | 1 | Enables the noise filter |
| irqEn | input | 1 | Enables the interrupt request |
| topMode | input | 1 | Waveform mode uses the capture register as TOP |
| cntVal | input | 16 | Value of the free-running counter |
| busAddr | input | 2 | Bus address: 0 low byte, 1 high/temp byte, 2 flag |
| rdEn | input | 1 | Bus read strobe |
| wrEn | input | 1 | Bus write strobe |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Bus read data (combinational from address) |
| intAck | input | 1 | Interrupt serviced, clears the flag |
| capFlag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 16-bit capture word, a two-stage synchronizer and a four-sample filter. With these values the filter's four-cycle delay and the rejection of short pulses can be seen within a handful of cycles. The same is true of the two-edge capture latency.

A behavioural reference model tracks the flag, the capture word and the temporary byte on every clock. Directed phases cover source switching, capture colliding with a flag clear, and commits that are blocked by the mode, and a random stretch follows them.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  typedef enum logic [1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_FLAG = 2'd2
  } ecuAddr_e;

  typedef struct packed {
    logic capture;
    logic clrFlag;
    logic wrTemp;
    logic commit;
    logic rdLow;
  } ecuStrb_t;
endpackage

// File: rtl/ecu_ctrl.sv
module ecu_ctrl
  import ecu_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pinIn,
  input  logic       cmpIn,
  input  logic       srcSel,
  input  logic       edgeRise,
  input  logic       filtEn,
  input  logic       topMode,
  input  logic [1:0] busAddr,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic       wrBit0,
  input  logic       intAck,
  output ecuStrb_t   strb
);
  localparam int HIST_W = FILT_LEN - 1;

  logic [SYNC_STAGES-1:0] pinSync;
  logic [SYNC_STAGES-1:0] cmpSync;
  logic selSig;
  logic filtLvl;
  logic prevTrig;
  logic trigNow;
  logic allEq;

  // synchronizers for both possible sources
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync <= '0;
      cmpSync <= '0;
    end else begin
      pinSync <= {pinSync[SYNC_STAGES-2:0], pinIn};
      cmpSync <= {cmpSync[SYNC_STAGES-2:0], cmpIn};
    end
  end

  // source mux after synchronization: a switch looks like a level change
  assign selSig = srcSel ? cmpSync[SYNC_STAGES-1] : pinSync[SYNC_STAGES-1];

  generate
    if (FILT_LEN > 1) begin : g_filt
      logic [HIST_W-1:0] hist;
      assign allEq = (hist == {HIST_W{selSig}});
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          hist <= '0;
        end else begin
          hist <= {hist[HIST_W-1:0], selSig} >> 0;
        end
      end
    end else begin : g_nofilt
      assign allEq = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtLvl  <= 1'b0;
      prevTrig <= 1'b0;
    end else begin
      if (allEq) filtLvl <= selSig;
      prevTrig <= trigNow;
    end
  end

  assign trigNow = filtEn ? filtLvl : selSig;

  always_comb begin
    strb.capture = (trigNow != prevTrig) && (trigNow == edgeRise);
    strb.clrFlag = intAck || (wrEn && busAddr == ADDR_FLAG && wrBit0);
    strb.wrTemp  = wrEn && busAddr == ADDR_HI;
    strb.commit  = wrEn && busAddr == ADDR_LO && topMode;
    strb.rdLow   = rdEn && busAddr == ADDR_LO;
  end
endmodule

// File: rtl/ecu_dpath.sv
module ecu_dpath
  import ecu_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ecuStrb_t           strb,
  input  logic [2*BUS_W-1:0] cntVal,
  input  logic [1:0]         busAddr,
  input  logic [BUS_W-1:0]   wrData,
  output logic [BUS_W-1:0]   rdData,
  output logic [2*BUS_W-1:0] capReg,
  output logic               capFlag
);
  logic [BUS_W-1:0] tempReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg  <= '0;
      tempReg <= '0;
      capFlag <= 1'b0;
    end else begin
      if (strb.capture)     capReg <= cntVal;
      else if (strb.commit) capReg <= {tempReg, wrData};

      if (strb.wrTemp)     tempReg <= wrData;
      else if (strb.rdLow) tempReg <= capReg[2*BUS_W-1:BUS_W];

      if (strb.capture)      capFlag <= 1'b1;
      else if (strb.clrFlag) capFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_LO:   rdData = capReg[BUS_W-1:0];
      ADDR_HI:   rdData = tempReg;
      ADDR_FLAG: rdData = {{(BUS_W-1){1'b0}}, capFlag};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 4,
  localparam int CNT_W      = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic             cmpIn,
  input  logic             srcSel,
  input  logic             edgeRise,
  input  logic             filtEn,
  input  logic             irqEn,
  input  logic             topMode,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [1:0]       busAddr,
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [BUS_W-1:0] wrData,
  output logic [BUS_W-1:0] rdData,
  input  logic             intAck,
  output logic             capFlag,
  output logic             irq
);
  ecuStrb_t         strb;
  logic [CNT_W-1:0] capVal;

  ecu_ctrl #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cmpIn(cmpIn), .srcSel(srcSel),
    .edgeRise(edgeRise), .filtEn(filtEn), .topMode(topMode),
    .busAddr(busAddr), .rdEn(rdEn), .wrEn(wrEn), .wrBit0(wrData[0]),
    .intAck(intAck), .strb(strb)
  );

  ecu_dpath #(.BUS_W(BUS_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cntVal(cntVal),
    .busAddr(busAddr), .wrData(wrData), .rdData(rdData),
    .capReg(capVal), .capFlag(capFlag)
  );

  assign irq = capFlag & irqEn;
endmodule

// File: rtl/ecu_checker.sv
module ecu_checker
  import ecu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input ecuStrb_t         strb,
  input logic [CNT_W-1:0] capReg,
  input logic [CNT_W-1:0] cntVal,
  input logic             capFlag,
  input logic             irqEn,
  input logic             irq
);
  // R4
  cap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> capFlag);

  // R4
  cap_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> capReg == $past(cntVal));

  // R7
  clear_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFlag && !strb.capture) |=> !capFlag);

  // R10
  no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.commit && !strb.capture) |=> $stable(capReg));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq);
endmodule

bind edge_capture_unit ecu_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .capReg(capVal), .cntVal(cntVal),
  .capFlag(capFlag), .irqEn(irqEn), .irq(irq)
);

// File: tb/sim_edge_capture_unit.sv
`timescale 1ns/1ps
module sim_edge_capture_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 0, cmpIn = 0, srcSel = 0, edgeRise = 1, filtEn = 0, irqEn = 0;
  logic topMode = 0, rdEn = 0, wrEn = 0, intAck = 0;
  logic [1:0]  busAddr = 0;
  logic [7:0]  wrData = 0;
  logic [15:0] cntVal = 0;
  logic [7:0]  rdData;
  logic        capFlag, irq;

  int errors = 0, checks = 0;
  string phase = "R1 reset";
  bit finished = 0;

  always #2.5 clk = ~clk;

  edge_capture_unit u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cmpIn(cmpIn), .srcSel(srcSel),
    .edgeRise(edgeRise), .filtEn(filtEn), .irqEn(irqEn), .topMode(topMode),
    .cntVal(cntVal), .busAddr(busAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .intAck(intAck), .capFlag(capFlag),
    .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit pq[$], cq[$], hq[$];
  bit fM, pM, flagM;
  logic [15:0] capM;
  logic [7:0]  tmpM;

  task automatic modelReset();
    pq = '{0, 0}; cq = '{0, 0}; hq = '{0, 0, 0};
    fM = 0; pM = 0; flagM = 0; capM = 0; tmpM = 0;
  endtask

  initial modelReset();

  always @(posedge clk) begin
    if (!rstN) modelReset();
    else begin
      bit selS, trg, capt, eq, clr;
      logic [15:0] oldCap;
      logic [7:0]  oldTmp;
      selS = srcSel ? cq[1] : pq[1];
      trg  = filtEn ? fM : selS;
      capt = (trg != pM) && (trg == edgeRise);
      pM   = trg;
      eq = 1;
      foreach (hq[i]) if (hq[i] != selS) eq = 0;
      if (eq) fM = selS;
      hq.push_front(selS); void'(hq.pop_back());
      pq.push_front(pinIn); void'(pq.pop_back());
      cq.push_front(cmpIn); void'(cq.pop_back());
      clr = intAck || (wrEn && busAddr == 2 && wrData[0]);
      oldCap = capM; oldTmp = tmpM;
      if (capt) capM = cntVal;
      else if (wrEn && busAddr == 0 && topMode) capM = {oldTmp, wrData};
      if (wrEn && busAddr == 1) tmpM = wrData;
      else if (rdEn && busAddr == 0) tmpM = oldCap[15:8];
      if (capt) flagM = 1;
      else if (clr) flagM = 0;
    end
  end

  function automatic logic [7:0] expRd();
    case (busAddr)
      2'd0: return capM[7:0];
      2'd1: return tmpM;
      2'd2: return {7'b0, flagM};
      default: return 8'h00;
    endcase
  endfunction

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (rstN && !finished) begin
      checks++;
      if (capFlag !== flagM) begin
        errors++;
        $display("FAIL [%s] R4 R7 R8 flag: got %b exp %b", phase, capFlag, flagM);
      end
      checks++;
      if (irq !== (flagM & irqEn)) begin
        errors++;
        $display("FAIL [%s] R6 irq: got %b exp %b", phase, irq, flagM & irqEn);
      end
      if (rdEn) begin
        checks++;
        if (rdData !== expRd()) begin
          errors++;
          $display("FAIL [%s] R9 R10 rdData@%0d: got %h exp %h", phase, busAddr, rdData, expRd());
        end
      end
    end
  end

  // free-running counter stimulus
  always @(negedge clk) cntVal <= cntVal + 16'd3;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busOp(input bit rd, input bit wr, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    rdEn = rd; wrEn = wr; busAddr = a; wrData = d;
    @(negedge clk);
    rdEn = 0; wrEn = 0; wrData = 0;
  endtask

  task automatic clearFlag();
    busOp(0, 1, 2'd2, 8'h01);
  endtask

  task automatic readWord();
    busOp(1, 0, 2'd0, 8'h00);
    busOp(1, 0, 2'd1, 8'h00);
  endtask

  task automatic finish();
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL [%s] watchdog expired", phase);
    finish();
  end

  initial begin
    idle(4);
    // R1: reset state at the ports
    checks++;
    if (capFlag !== 0 || irq !== 0 || rdData !== 0) begin
      errors++;
      $display("FAIL R1 reset: flag=%b irq=%b rd=%h exp 0 0 00", capFlag, irq, rdData);
    end
    rstN = 1;
    idle(2);
    busOp(1, 0, 2'd1, 0);   // R1 temp byte reads 0

    phase = "R2 R4 rising";
    edgeRise = 1; pinIn = 1; idle(6);
    readWord();
    clearFlag();
    pinIn = 0; idle(6);      // falling edge ignored with rising polarity

    phase = "R9 temp holds";
    busOp(1, 0, 2'd1, 0);
    pinIn = 1; idle(6);      // new capture, high read without low read
    busOp(1, 0, 2'd1, 0);
    readWord();
    clearFlag();

    phase = "R2 falling";
    edgeRise = 0; pinIn = 0; idle(6);
    readWord(); clearFlag();
    pinIn = 1; idle(6);

    phase = "R3 unselected";
    cmpIn = 1; idle(4); cmpIn = 0; idle(6);
    cmpIn = 1; idle(4);      // match pin before switch
    srcSel = 1; idle(4);
    cmpIn = 0; idle(6);      // falling on comparator captures
    readWord(); clearFlag();
    pinIn = 0; idle(4); pinIn = 1; idle(6);

    phase = "R6 R7 irq";
    irqEn = 1; cmpIn = 1; idle(3); cmpIn = 0; idle(6);
    busOp(0, 1, 2'd2, 8'hFE); // bit0 clear: no effect
    @(negedge clk) intAck = 1; @(negedge clk) intAck = 0;
    idle(2);

    phase = "R8 collision";
    for (int k = 0; k < 6; k++) begin
      cmpIn = 1; idle(4);
      cmpIn = 0; idle(k);
      clearFlag(); idle(4);
      clearFlag();
    end

    phase = "R5 filter";
    filtEn = 1; idle(6);
    cmpIn = 1; idle(2); cmpIn = 0; idle(10);  // rising pulse, falling polarity
    edgeRise = 1; idle(2);
    cmpIn = 1; idle(3); cmpIn = 0; idle(10);  // 3-cycle pulse rejected
    cmpIn = 1; idle(12);                      // accepted after delay
    readWord(); clearFlag();
    filtEn = 0; idle(4);

    phase = "R10 write";
    topMode = 0;
    busOp(0, 1, 2'd1, 8'hA5); busOp(0, 1, 2'd0, 8'h3C);
    readWord();
    topMode = 1;
    busOp(0, 1, 2'd1, 8'h5A); busOp(0, 1, 2'd0, 8'hC3);
    readWord();
    topMode = 0;

    phase = "R11 source switch";
    edgeRise = 0; srcSel = 0; pinIn = 1; cmpIn = 0; idle(6);
    clearFlag(); idle(2);
    srcSel = 1; idle(4);
    clearFlag(); idle(2);
    edgeRise = 1; srcSel = 0; idle(4);
    clearFlag(); idle(2);

    phase = "random";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      pinIn = $urandom_range(0, 3) == 0 ? ~pinIn : pinIn;
      cmpIn = $urandom_range(0, 3) == 0 ? ~cmpIn : cmpIn;
      if ($urandom_range(0, 15) == 0) srcSel = ~srcSel;
      if ($urandom_range(0, 15) == 0) edgeRise = ~edgeRise;
      if ($urandom_range(0, 31) == 0) filtEn = ~filtEn;
      irqEn = $urandom_range(0, 1);
      topMode = $urandom_range(0, 1);
      intAck = $urandom_range(0, 7) == 0;
      busAddr = 2'($urandom_range(0, 3));
      wrData = 8'($urandom);
      rdEn = $urandom_range(0, 1);
      wrEn = !rdEn && $urandom_range(0, 3) == 0;
    end
    @(negedge clk);
    rdEn = 0; wrEn = 0; intAck = 0;
    idle(4);
    finish();
  end
endmodule